// File: doc/BRIEF.md
# Serial Transfer Pause Controller

This block sits beside the shift logic of a serial slave and lets a master pause a transfer partway through without losing its place. It samples the serial clock, the active-low chip select, an active-low pause pin and the current bus-width mode, all in the system clock domain. From these it produces two qualified enables for the shift logic: one for the sampling (rising) serial clock edge and one for the output-update (falling) serial clock edge. It also produces a force-high-impedance signal for the data output driver.

A pause starts and ends only while the serial clock is low. If the pause pin changes while the clock is high, the change takes effect at the next falling clock edge. The output-disable signal ignores this alignment and follows the pause pin in the same cycle. At quad width the pause pin is a data line, so the pause function is switched off.

All inputs are taken to be synchronous to `clk_i`, and the serial clock is oversampled. Width codes are 2'b00 single, 2'b01 dual and 2'b10 quad.

Top module: `hold_ctl`

## Requirements
- R1: Reset clears the pause and loads the serial clock history with its idle level, which is low by default. After reset, a transfer whose pause pin is high has its first rising serial clock edge enabled.
- R2: When the block is selected and not paused, `sample_en_o` pulses for exactly one cycle on each low-to-high serial clock transition, and `update_en_o` pulses for exactly one cycle on each high-to-low transition. The two never pulse together.
- R3: If the pause pin falls while the serial clock is low, the pause starts in that cycle. The next rising edge is the first edge suppressed.
- R4: If the pause pin falls while the serial clock is high, the pause starts at the next falling edge, and that falling edge is the first edge suppressed. A low pulse on the pause pin that ends before the clock falls causes no pause.
- R5: If the pause pin rises while the serial clock is low, the transfer resumes in that cycle, and the next rising edge is enabled.
- R6: If the pause pin rises while the serial clock is high during a pause, the pause lasts until the next falling edge, and that falling edge is enabled.
- R7: While paused, no serial clock edge produces an enable, however many edges arrive.
- R8: While selected at single or dual width, `out_hiz_o` equals the inverse of the pause pin in the same cycle, whatever the serial clock level.
- R9: At quad width (code 2'b10), the pause pin has no effect: it does not pause the transfer and does not force high impedance.
- R10: While chip select is high, both enables stay low, `out_hiz_o` is high, and any pause is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock level, synchronous to clk_i |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Pause request pin, active low |
| width_i | input | 2 | Bus width: 00 single, 01 dual, 10 quad |
| sample_en_o | output | 1 | Enable for the rising-edge input sampling |
| update_en_o | output | 1 | Enable for the falling-edge output update |
| out_hiz_o | output | 1 | Forces the data output to high impedance |

## Verification
The assertions check the rules that hold on every cycle. The enables are mutually exclusive and stay low while deselected or while the pin is low with the clock low. The output-disable responds to each pin edge in that same cycle. The pause state is frozen while the clock is high, and it is cleared at quad width or on deselect. Only the bench scenarios can show which edge is first suppressed when the pin falls with the clock high and with it low, whether a brief pin pulse during clock-high is absorbed, and whether a reset mid-pause lets the next transfer start cleanly.

// File: rtl/hold_ctl_pkg.sv
package hold_ctl_pkg;
  localparam int unsigned BW_W = 2;

  typedef enum logic [BW_W-1:0] {
    BW_SINGLE = 2'b00,
    BW_DUAL   = 2'b01,
    BW_QUAD   = 2'b10,
    BW_RSVD   = 2'b11
  } bus_width_e;
endpackage

// File: rtl/hold_sck_edge.sv
module hold_sck_edge #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= IDLE_LVL;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/hold_pause_track.sv
module hold_pause_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic quad_i,
  output logic paused_o
);
  logic paused_q;
  logic paused_d;

  // pause state may only change while sck is low
  always_comb begin
    if (cs_ni || quad_i) paused_d = 1'b0;
    else if (sck_i)      paused_d = paused_q;
    else                 paused_d = ~hold_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) paused_q <= 1'b0;
    else         paused_q <= paused_d;
  end

  assign paused_o = paused_d;

  p_pause_frozen_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && sck_i && !quad_i) |=> $stable(paused_q));

  p_quad_clears_pause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_i |=> !paused_q);

  p_desel_clears_pause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !paused_q);
endmodule

// File: rtl/hold_out_gate.sv
module hold_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic quad_i,
  input  logic paused_i,
  output logic sample_en_o,
  output logic update_en_o,
  output logic out_hiz_o
);
  logic live;

  assign live        = ~cs_ni & ~paused_i;
  assign sample_en_o = rise_i & live;
  assign update_en_o = fall_i & live;
  // tristate tracks the pin directly, not the clock-aligned pause
  assign out_hiz_o   = cs_ni | (~hold_ni & ~quad_i);

  p_enables_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_en_o, update_en_o}));

  p_hiz_on_hold_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !quad_i && $fell(hold_ni)) |-> out_hiz_o);

  p_drive_on_hold_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && $rose(hold_ni)) |-> !out_hiz_o);

  p_desel_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!sample_en_o && !update_en_o && out_hiz_o));
endmodule

// File: rtl/hold_ctl.sv
module hold_ctl
  import hold_ctl_pkg::*;
#(
  parameter logic SCK_IDLE = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_i,
  input  logic            cs_ni,
  input  logic            hold_ni,
  input  logic [BW_W-1:0] width_i,
  output logic            sample_en_o,
  output logic            update_en_o,
  output logic            out_hiz_o
);
  logic quad;
  logic rise, fall;
  logic paused;

  assign quad = (width_i == BW_QUAD);

  hold_sck_edge #(.IDLE_LVL(SCK_IDLE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  hold_pause_track u_pause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_i),
    .cs_ni    (cs_ni),
    .hold_ni  (hold_ni),
    .quad_i   (quad),
    .paused_o (paused)
  );

  hold_out_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .cs_ni       (cs_ni),
    .hold_ni     (hold_ni),
    .quad_i      (quad),
    .paused_i    (paused),
    .sample_en_o (sample_en_o),
    .update_en_o (update_en_o),
    .out_hiz_o   (out_hiz_o)
  );

  p_low_hold_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !sck_i && !hold_ni && width_i != BW_QUAD) |-> (!sample_en_o && !update_en_o));

  p_quad_drives_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && width_i == BW_QUAD) |-> !out_hiz_o);
endmodule

// File: tb/hold_ctl_tb.sv
module hold_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       hold_n = 1'b1;
  logic [1:0] width = 2'b00;
  logic       sample_en, update_en, out_hiz;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  hold_ctl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sck_i       (sck),
    .cs_ni       (cs_n),
    .hold_ni     (hold_n),
    .width_i     (width),
    .sample_en_o (sample_en),
    .update_en_o (update_en),
    .out_hiz_o   (out_hiz)
  );

  // {req[3:0], cs_n, hold_n, sck, width[1:0], exp_sample, exp_update, exp_hiz}
  localparam int NV = 37;
  localparam logic [11:0] VEC [NV] = '{
    12'b1010_1_1_0_00_0_0_1,  // R10 idle deselected
    12'b0010_0_1_0_00_0_0_0,  // R2
    12'b0010_0_1_1_00_1_0_0,  // R2 rise
    12'b0010_0_1_0_00_0_1_0,  // R2 fall
    12'b0010_0_1_1_00_1_0_0,
    12'b1000_0_0_1_00_0_0_1,  // R8 pin low while sck high
    12'b0100_0_0_0_00_0_0_1,  // R4 falling edge first suppressed
    12'b0100_0_0_1_00_0_0_1,
    12'b0111_0_0_0_00_0_0_1,  // R7
    12'b0101_0_1_0_00_0_0_0,  // R5 release while low
    12'b0101_0_1_1_00_1_0_0,  // R5 next rise enabled
    12'b0010_0_1_0_00_0_1_0,
    12'b0011_0_0_0_00_0_0_1,  // R3 pause at once
    12'b0011_0_0_1_00_0_0_1,  // R3 rise first suppressed
    12'b1000_0_1_1_00_0_0_0,  // R8/R6 release while high
    12'b0110_0_1_0_00_0_1_0,  // R6 fall enabled
    12'b0010_0_1_1_00_1_0_0,
    12'b0100_0_0_1_00_0_0_1,  // R4 short pulse while high
    12'b0100_0_1_1_00_0_0_0,
    12'b0100_0_1_0_00_0_1_0,  // R4 no pause taken
    12'b0011_0_0_0_01_0_0_1,  // R3 dual width
    12'b0011_0_0_1_01_0_0_1,
    12'b0110_0_1_1_01_0_0_0,
    12'b0110_0_1_0_01_0_1_0,
    12'b1001_0_0_0_10_0_0_0,  // R9 quad ignores pin
    12'b1001_0_0_1_10_1_0_0,
    12'b1001_0_0_0_10_0_1_0,
    12'b1001_0_1_1_10_1_0_0,
    12'b0010_0_1_0_00_0_1_0,
    12'b0011_0_0_0_00_0_0_1,
    12'b1010_1_0_1_00_0_0_1,  // R10 deselect mid pause
    12'b1010_1_1_0_00_0_0_1,
    12'b1010_0_1_0_00_0_0_0,
    12'b1010_0_1_1_00_1_0_0,  // R10 new transfer runs
    12'b0010_0_1_0_00_0_1_0,
    12'b1010_1_1_1_00_0_0_1,
    12'b1010_1_1_0_00_0_0_1
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input logic es, input logic eu, input logic eh);
    chk(req, "sample_en", sample_en, es);
    chk(req, "update_en", update_en, eu);
    chk(req, "out_hiz", out_hiz, eh);
  endtask

  task automatic drive(input logic c, input logic h, input logic s, input logic [1:0] w);
    @(negedge clk);
    cs_n = c; hold_n = h; sck = s; width = w;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk_all(1, 1'b0, 1'b0, 1'b1);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      drive(v[7], v[6], v[5], v[4:3]);
      chk_all(int'(v[11:8]), v[2], v[1], v[0]);
    end

    // R7: a long train of edges during a pause yields nothing
    drive(1'b0, 1'b1, 1'b0, 2'b00);
    drive(1'b0, 1'b0, 1'b0, 2'b00);
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 1'b0, 1'b1, 2'b00);
      chk_all(7, 1'b0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b0, 2'b00);
      chk_all(7, 1'b0, 1'b0, 1'b1);
    end

    // R1: reset in mid pause, then a clean rising edge is enabled
    drive(1'b0, 1'b0, 1'b1, 2'b00);
    chk(7, "sample_en paused", sample_en, 1'b0);
    @(negedge clk);
    rst_ni = 1'b0;
    hold_n = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(1, "sample_en after reset", sample_en, 1'b1);
    chk(1, "out_hiz after reset", out_hiz, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule